// File: doc/BRIEF.md
# Byte-Serial Instruction Decoder

This block sits behind an instruction fetch path and turns a stream of instruction bytes into decoded instruction records. It accepts one byte per cycle under a valid/ready handshake. The target is a small 64-bit teaching instruction set in which every instruction is 1, 2, 9 or 10 bytes long. The upper nibble of an instruction's first byte fixes that length. The block gathers the optional register-pair byte and the optional 8-byte little-endian constant. When the last byte of an instruction has arrived, it presents a single record under its own valid/ready handshake.

Each record holds the operation class, the function or condition nibble, both register fields, the constant, the instruction length and the byte offset of the instruction within the stream. It also carries two flags: one for an unknown operation class and one for the stop instruction. A synchronous reset drops any partly received instruction, so the next byte is taken as a first byte and offsets count again from zero.

Top module: `instr_stream_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, out_valid is 0 and in_ready is 1. After reset, the next accepted byte begins a new instruction at stream offset 0, even if reset came in the middle of an instruction.
- R2: The first byte of an instruction is split into two nibbles. Bits 7:4 appear on out_icode and bits 3:0 appear on out_ifun.
- R3: out_len, and the number of bytes the instruction consumes, depend on the operation class. Classes 0x0, 0x1 and 0x9 take 1 byte. Classes 0x2, 0x6, 0xA and 0xB take 2 bytes. Classes 0x7 and 0x8 take 9 bytes. Classes 0x3, 0x4 and 0x5 take 10 bytes.
- R4: Classes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB have a second byte. Its bits 7:4 appear on out_ra and its bits 3:0 appear on out_rb.
- R5: The constant follows the register byte in classes 0x3, 0x4 and 0x5, and follows the first byte directly in classes 0x7 and 0x8. It is 8 bytes, little-endian: the first constant byte received becomes out_imm[7:0] and the last becomes out_imm[63:56].
- R6: When an instruction has no register byte, out_ra and out_rb are both 0xF. When it has no constant, out_imm is 0.
- R7: A first byte whose class is 0xC to 0xF raises out_invalid, with out_len 1. The byte that follows is taken as the first byte of the next instruction.
- R8: Class 0x0 (for example the byte 0x00) raises out_halt and decodes as a 1-byte instruction. No other class raises out_halt.
- R9: While out_valid is 1 and out_ready is 0, every record output holds its value and out_valid stays 1. While out_valid is 1, in_ready is 0.
- R10: out_offset is the number of bytes accepted since reset before the instruction's first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_byte holds a stream byte |
| in_byte | input | 8 | Next instruction byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_valid | output | 1 | A decoded record is presented |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_icode | output | 4 | Operation class (first byte bits 7:4) |
| out_ifun | output | 4 | Function or condition code (first byte bits 3:0) |
| out_ra | output | 4 | First register field, 0xF when absent |
| out_rb | output | 4 | Second register field, 0xF when absent |
| out_imm | output | 8*IMM_BYTES | Little-endian constant, zero when absent |
| out_len | output | LEN_W | Instruction length in bytes |
| out_offset | output | OFS_W | Stream offset of the first byte |
| out_invalid | output | 1 | Unknown operation class |
| out_halt | output | 1 | Stop instruction |

## Verification
The stream covers every operation class, so each of the four lengths is exercised, and the register fields must land in the right nibbles. Constants are chosen so byte order shows up: one with a single low byte such as 0x84, one with two low bytes such as 0x123, and one with eight distinct bytes. A reversed or shifted assembly therefore cannot match. Unknown classes are placed directly in front of valid instructions, which exposes any decoder that consumes extra bytes after them. The stream is also run with gaps in in_valid and with long periods of out_ready low, which tests how records are held. Finally, a reset lands in the middle of a 10-byte instruction, which tests both the offset restart and the return to first-byte decoding.

// File: rtl/isd_pkg.sv
package isd_pkg;

    typedef enum logic [1:0] {
        ST_FIRST = 2'd0,
        ST_REGS  = 2'd1,
        ST_CONST = 2'd2,
        ST_HOLD  = 2'd3
    } isd_state_e;

    localparam logic [3:0] NO_REG     = 4'hF;
    localparam logic [3:0] CLS_STOP   = 4'h0;
    localparam logic [3:0] CLS_NOP    = 4'h1;
    localparam logic [3:0] CLS_RMOV   = 4'h2;
    localparam logic [3:0] CLS_IMOV   = 4'h3;
    localparam logic [3:0] CLS_STORE  = 4'h4;
    localparam logic [3:0] CLS_LOAD   = 4'h5;
    localparam logic [3:0] CLS_ALU    = 4'h6;
    localparam logic [3:0] CLS_JUMP   = 4'h7;
    localparam logic [3:0] CLS_CALL   = 4'h8;
    localparam logic [3:0] CLS_RET    = 4'h9;
    localparam logic [3:0] CLS_PUSH   = 4'hA;
    localparam logic [3:0] CLS_POP    = 4'hB;

    typedef struct packed {
        logic has_reg;
        logic has_const;
        logic invalid;
        logic stop;
    } isd_class_t;

endpackage

// File: rtl/isd_classify.sv
module isd_classify
    import isd_pkg::*;
#(
    parameter int IMM_BYTES = 8,
    parameter int LEN_W     = $clog2(IMM_BYTES + 3)
) (
    input  logic [3:0]       icode,
    output isd_class_t       cls,
    output logic [LEN_W-1:0] len
);

    always_comb begin
        cls = '0;
        unique case (icode)
            CLS_STOP:                        cls.stop      = 1'b1;
            CLS_NOP, CLS_RET:                cls           = '0;
            CLS_RMOV, CLS_ALU,
            CLS_PUSH, CLS_POP:               cls.has_reg   = 1'b1;
            CLS_IMOV, CLS_STORE, CLS_LOAD: begin
                cls.has_reg   = 1'b1;
                cls.has_const = 1'b1;
            end
            CLS_JUMP, CLS_CALL:              cls.has_const = 1'b1;
            default:                         cls.invalid   = 1'b1;
        endcase
        len = LEN_W'(1) + LEN_W'(cls.has_reg)
            + (cls.has_const ? LEN_W'(IMM_BYTES) : LEN_W'(0));
    end

endmodule

// File: rtl/isd_const_lane.sv
module isd_const_lane #(
    parameter int IMM_BYTES = 8,
    parameter int IDX_W     = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1
) (
    input  logic [8*IMM_BYTES-1:0] imm_in,
    input  logic [IDX_W-1:0]       lane,
    input  logic [7:0]             data,
    output logic [8*IMM_BYTES-1:0] imm_out
);

    for (genvar g = 0; g < IMM_BYTES; g++) begin : g_lane
        assign imm_out[8*g +: 8] = (lane == IDX_W'(g)) ? data : imm_in[8*g +: 8];
    end

endmodule

// File: rtl/instr_stream_decoder.sv
module instr_stream_decoder
    import isd_pkg::*;
#(
    parameter int IMM_BYTES = 8,
    parameter int OFS_W     = 32,
    parameter int LEN_W     = $clog2(IMM_BYTES + 3)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    output logic                   in_ready,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [3:0]             out_icode,
    output logic [3:0]             out_ifun,
    output logic [3:0]             out_ra,
    output logic [3:0]             out_rb,
    output logic [8*IMM_BYTES-1:0] out_imm,
    output logic [LEN_W-1:0]       out_len,
    output logic [OFS_W-1:0]       out_offset,
    output logic                   out_invalid,
    output logic                   out_halt
);

    localparam int IMM_W = 8 * IMM_BYTES;
    localparam int IDX_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(IMM_BYTES - 1);

    typedef struct packed {
        isd_state_e       st;
        logic [3:0]       icode;
        logic [3:0]       ifun;
        logic [3:0]       ra;
        logic [3:0]       rb;
        logic [IMM_W-1:0] imm;
        logic [IDX_W-1:0] lane;
        logic [LEN_W-1:0] len;
        logic             invalid;
        logic             stop;
        logic             has_const;
        logic [OFS_W-1:0] pos;
        logic [OFS_W-1:0] start;
    } dec_regs_t;

    dec_regs_t        dec_d, dec_q;
    isd_class_t       cls;
    logic [LEN_W-1:0] cls_len;
    logic [IMM_W-1:0] imm_ins;
    logic             take;

    isd_classify #(.IMM_BYTES(IMM_BYTES), .LEN_W(LEN_W)) u_classify (
        .icode (in_byte[7:4]),
        .cls   (cls),
        .len   (cls_len)
    );

    isd_const_lane #(.IMM_BYTES(IMM_BYTES), .IDX_W(IDX_W)) u_const_lane (
        .imm_in  (dec_q.imm),
        .lane    (dec_q.lane),
        .data    (in_byte),
        .imm_out (imm_ins)
    );

    assign in_ready = (dec_q.st != ST_HOLD);
    assign take     = in_valid && in_ready;

    always_comb begin
        dec_d = dec_q;
        if (take) begin
            dec_d.pos = dec_q.pos + OFS_W'(1);
        end
        unique case (dec_q.st)
            ST_FIRST: begin
                if (take) begin
                    dec_d.icode     = in_byte[7:4];
                    dec_d.ifun      = in_byte[3:0];
                    dec_d.ra        = NO_REG;
                    dec_d.rb        = NO_REG;
                    dec_d.imm       = '0;
                    dec_d.lane      = '0;
                    dec_d.len       = cls_len;
                    dec_d.invalid   = cls.invalid;
                    dec_d.stop      = cls.stop;
                    dec_d.has_const = cls.has_const;
                    dec_d.start     = dec_q.pos;
                    if (cls.has_reg) begin
                        dec_d.st = ST_REGS;
                    end else if (cls.has_const) begin
                        dec_d.st = ST_CONST;
                    end else begin
                        dec_d.st = ST_HOLD;
                    end
                end
            end
            ST_REGS: begin
                if (take) begin
                    dec_d.ra = in_byte[7:4];
                    dec_d.rb = in_byte[3:0];
                    dec_d.st = dec_q.has_const ? ST_CONST : ST_HOLD;
                end
            end
            ST_CONST: begin
                if (take) begin
                    dec_d.imm  = imm_ins;
                    dec_d.lane = dec_q.lane + IDX_W'(1);
                    if (dec_q.lane == LAST_LANE) begin
                        dec_d.st = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (out_ready) begin
                    dec_d.st = ST_FIRST;
                end
            end
            default: dec_d.st = ST_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign out_valid   = (dec_q.st == ST_HOLD);
    assign out_icode   = dec_q.icode;
    assign out_ifun    = dec_q.ifun;
    assign out_ra      = dec_q.ra;
    assign out_rb      = dec_q.rb;
    assign out_imm     = dec_q.imm;
    assign out_len     = dec_q.len;
    assign out_offset  = dec_q.start;
    assign out_invalid = dec_q.invalid;
    assign out_halt    = dec_q.stop;

endmodule

// File: rtl/isd_checker.sv
module isd_checker #(
    parameter int IMM_BYTES = 8,
    parameter int OFS_W     = 32,
    parameter int LEN_W     = $clog2(IMM_BYTES + 3)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [3:0]             out_icode,
    input logic [3:0]             out_ifun,
    input logic [3:0]             out_ra,
    input logic [3:0]             out_rb,
    input logic [8*IMM_BYTES-1:0] out_imm,
    input logic [LEN_W-1:0]       out_len,
    input logic [OFS_W-1:0]       out_offset,
    input logic                   out_invalid,
    input logic                   out_halt
);

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_icode) && $stable(out_ifun)
            && $stable(out_ra) && $stable(out_rb) && $stable(out_imm)
            && $stable(out_len) && $stable(out_offset)
            && $stable(out_invalid) && $stable(out_halt)); // R9

    AST_NO_INPUT_WHILE_FULL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R9

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len == LEN_W'(1)) || (out_len == LEN_W'(2))
            || (out_len == LEN_W'(IMM_BYTES + 1)) || (out_len == LEN_W'(IMM_BYTES + 2))); // R3

    AST_INVALID_SHORT: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_invalid |-> out_len == LEN_W'(1) && !out_halt); // R7

    AST_HALT_SHORT: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_halt |-> out_len == LEN_W'(1) && out_icode == 4'h0); // R8

    AST_SHORT_FIELDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_len == LEN_W'(1) |-> out_ra == 4'hF && out_rb == 4'hF
            && out_imm == '0); // R6

endmodule

bind instr_stream_decoder isd_checker #(
    .IMM_BYTES (IMM_BYTES),
    .OFS_W     (OFS_W),
    .LEN_W     (LEN_W)
) u_isd_checker (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_icode   (out_icode),
    .out_ifun    (out_ifun),
    .out_ra      (out_ra),
    .out_rb      (out_rb),
    .out_imm     (out_imm),
    .out_len     (out_len),
    .out_offset  (out_offset),
    .out_invalid (out_invalid),
    .out_halt    (out_halt)
);

// File: tb/instr_stream_decoder_test.sv
`timescale 1ns/1ps
module instr_stream_decoder_test;

    localparam int IMM_BYTES = 8;
    localparam int OFS_W     = 32;
    localparam int LEN_W     = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [3:0]  out_icode, out_ifun, out_ra, out_rb;
    logic [63:0] out_imm;
    logic [LEN_W-1:0] out_len;
    logic [OFS_W-1:0] out_offset;
    logic        out_invalid, out_halt;

    always #2 clk = ~clk;

    instr_stream_decoder #(.IMM_BYTES(IMM_BYTES), .OFS_W(OFS_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_icode(out_icode),
        .out_ifun(out_ifun), .out_ra(out_ra), .out_rb(out_rb), .out_imm(out_imm),
        .out_len(out_len), .out_offset(out_offset), .out_invalid(out_invalid),
        .out_halt(out_halt)
    );

    typedef struct packed {
        logic [3:0]  icode, ifun, ra, rb;
        logic [63:0] imm;
        logic [3:0]  len;
        logic [31:0] ofs;
        logic        inv, halt;
    } rec_t;

    rec_t exp_q[$];
    int   compared = 0;
    int   mismatched = 0;
    int   bench_ofs = 0;
    bit   stall_mode = 1'b0;
    int   gap = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        forever begin
            @(negedge clk);
            if (in_ready) begin
                @(posedge clk);
                #1;
                break;
            end
        end
        in_valid = 1'b0;
        repeat (gap) begin
            @(posedge clk);
            #1;
        end
    endtask

    // expected record built from the length and field rules alone
    task automatic issue(input logic [7:0] op, input logic [7:0] rg, input logic [63:0] k);
        rec_t e;
        bit   hr, hk;
        hr = 1'b0;
        hk = 1'b0;
        case (op[7:4])
            4'h2, 4'h6, 4'hA, 4'hB: hr = 1'b1;
            4'h3, 4'h4, 4'h5: begin hr = 1'b1; hk = 1'b1; end
            4'h7, 4'h8: hk = 1'b1;
            default: ;
        endcase
        e.icode = op[7:4];
        e.ifun  = op[3:0];
        e.ra    = hr ? rg[7:4] : 4'hF;
        e.rb    = hr ? rg[3:0] : 4'hF;
        e.imm   = hk ? k : 64'd0;
        e.len   = 4'(1 + (hr ? 1 : 0) + (hk ? 8 : 0));
        e.ofs   = bench_ofs;
        e.inv   = op[7:4] > 4'hB;
        e.halt  = op[7:4] == 4'h0;
        exp_q.push_back(e);
        bench_ofs += int'(e.len);
        put_byte(op);
        if (hr) put_byte(rg);
        if (hk) for (int i = 0; i < 8; i++) put_byte(k[8*i +: 8]);
    endtask

    // out_ready pattern
    int rcnt = 0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            rcnt++;
            out_ready = stall_mode ? ((rcnt % 5) == 4) : 1'b1;
        end
    end

    // monitor: compare on handshake, check hold while stalled
    rec_t snap;
    bit   snap_ok = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && snap_ok) begin
                chk("R9 valid held", 64'(out_valid), 64'd1);
                chk("R9 record held", 64'({out_icode, out_ifun, out_ra, out_rb, out_imm,
                    out_len, out_offset, out_invalid, out_halt}), 64'(snap));
                chk("R9 input blocked", 64'(in_ready), 64'd0);
            end
            snap_ok = 1'b0;
            if (!rst && out_valid && !out_ready) begin
                snap = {out_icode, out_ifun, out_ra, out_rb, out_imm, out_len,
                        out_offset, out_invalid, out_halt};
                snap_ok = 1'b1;
            end
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected record", 64'(out_icode), 64'hFFFF);
                end else begin
                    rec_t e;
                    e = exp_q.pop_front();
                    chk("R2 icode", 64'(out_icode), 64'(e.icode));
                    chk("R2 ifun", 64'(out_ifun), 64'(e.ifun));
                    chk("R4/R6 ra", 64'(out_ra), 64'(e.ra));
                    chk("R4/R6 rb", 64'(out_rb), 64'(e.rb));
                    chk("R5/R6 imm", out_imm, e.imm);
                    chk("R3 len", 64'(out_len), 64'(e.len));
                    chk("R10 offset", 64'(out_offset), 64'(e.ofs));
                    chk("R7 invalid", 64'(out_invalid), 64'(e.inv));
                    chk("R8 halt", 64'(out_halt), 64'(e.halt));
                end
            end
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL R9 watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset out_valid", 64'(out_valid), 64'd0);
        chk("R1 reset in_ready", 64'(in_ready), 64'd1);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset out_valid", 64'(out_valid), 64'd0);
        chk("R1 after reset in_ready", 64'(in_ready), 64'd1);
        @(posedge clk);
        #1;

        // back-to-back, consumer always ready
        issue(8'h30, 8'hF0, 64'h1);
        issue(8'h60, 8'h70, 64'd0);
        issue(8'h90, 8'h00, 64'd0);
        issue(8'h72, 8'h00, 64'h84);
        issue(8'h75, 8'h00, 64'h123);
        issue(8'h20, 8'h12, 64'd0);
        issue(8'h61, 8'h37, 64'd0);
        issue(8'h00, 8'h00, 64'd0);
        issue(8'hC0, 8'h00, 64'd0);
        issue(8'h10, 8'h00, 64'd0);
        issue(8'hFF, 8'h00, 64'd0);
        issue(8'hA0, 8'h2F, 64'd0);
        drain();

        // input gaps and a stalling consumer
        stall_mode = 1'b1;
        gap = 2;
        issue(8'h40, 8'h12, 64'h0123_4567_89AB_CDEF);
        issue(8'hD5, 8'h00, 64'd0);
        issue(8'hB0, 8'h3F, 64'd0);
        issue(8'h80, 8'h00, 64'hFEDC_BA98_7654_3210);
        issue(8'h50, 8'hE4, 64'h8000_0000_0000_0001);
        issue(8'h63, 8'hAB, 64'd0);
        issue(8'hE7, 8'h00, 64'd0);
        issue(8'h00, 8'h00, 64'd0);
        drain();
        stall_mode = 1'b0;
        gap = 0;

        // reset in the middle of a 10-byte instruction
        put_byte(8'h30);
        put_byte(8'hF0);
        put_byte(8'h55);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        bench_ofs = 0;
        @(negedge clk);
        chk("R1 mid reset out_valid", 64'(out_valid), 64'd0);
        chk("R1 mid reset in_ready", 64'(in_ready), 64'd1);
        @(posedge clk);
        #1;
        issue(8'h10, 8'h00, 64'd0);
        issue(8'h62, 8'h89, 64'd0);
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule